// File: doc/BRIEF.md
# Descriptor Status Writeback and Error Halt Controller

This block sits in the control path of a scatter-gather DMA engine that moves data from memory to a stream. Each fetched descriptor is screened before any data moves. A descriptor that already carries its completed flag is stale. A descriptor whose buffer length is zero within the usable width is rejected. A good descriptor produces a one-cycle command to the data mover, carrying the masked length.

While the mover works, the block gathers its responses. Error flags are ORed across every response of the descriptor, and the byte count is taken from the final response. One cycle after that final response, the block presents a 32-bit status word with a single-cycle writeback strobe.

Any error starts a two-step halt. In the cycle after the error is detected, a one-cycle pulse asks for the run/stop control bit to be cleared. The halted flag rises only once the engine reports idle and this block has no transfer or writeback in flight. Software leaves the halted state by clearing the error state and then raising run/stop again.

Top module: `dsc_status_wb`

## Requirements
- R1: The status word carries the transferred byte count in bits 25:0. The count is the final mover response's count masked to LEN_W bits, so every bit from LEN_W up to 25 reads zero. The mover command length is the descriptor length masked the same way.
- R2: Bits 27:26 of every written-back status word are zero.
- R3: A descriptor whose masked length is zero issues no mover command. Its status word has bit 28 (internal error) set, bit 31 clear and a count of 0.
- R4: Bit 29 (slave error) and bit 30 (decode error) are set when any response of the descriptor flagged that error, even if later responses are clean. Bit 31 (completed) is 1 exactly when bits 30:28 are all 0.
- R5: A fetched descriptor with its completed flag set causes no mover command and no writeback. It raises `sg_int_err`, which holds until `err_clr` is applied while halted.
- R6: On the first error of a run, `rs_clr` pulses for exactly one cycle, in the cycle after detection. `halted` rises only at an edge where `eng_idle` is high and no transfer or writeback of this block is pending.
- R7: Once set, `halted` clears only on a rising edge of `rs_in` seen after `err_clr` was applied in the halted state. A rising edge of `rs_in` before `err_clr` leaves it set.
- R8: Each accepted non-stale descriptor gives exactly one `wb_valid` pulse lasting one cycle. For a transfer, the pulse comes in the cycle after the final mover response. For a zero-length descriptor, it comes in the cycle after acceptance.
- R9: When MICRO is set, `wb_valid` never asserts. The halt sequence behaves as in normal mode.
- R10: `len_mismatch` is high during the writeback cycle of an error-free transfer whose reported count differs from the commanded length, and low otherwise.
- R11: A descriptor is accepted only when the block is idle, `rs_in` is high and no halt is in progress. Any other descriptor is ignored and issues no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsc_valid | input | 1 | A fetched descriptor is presented this cycle |
| dsc_len | input | 26 | Buffer length from the descriptor control field |
| dsc_cmplt | input | 1 | Completed flag of the fetched status word |
| rs_in | input | 1 | Current run/stop control bit |
| err_clr | input | 1 | Software reset of the error state |
| eng_idle | input | 1 | Engine fully drained |
| mov_cmd_valid | output | 1 | One-cycle command to the data mover |
| mov_cmd_len | output | 26 | Command length (masked) |
| mov_resp | input | 1 | Mover response valid |
| mov_last | input | 1 | Final response of the descriptor |
| mov_slverr | input | 1 | Slave error on the memory read side |
| mov_decerr | input | 1 | Decode error (invalid address) |
| mov_bytes | input | 26 | Bytes transferred, valid with the final response |
| wb_valid | output | 1 | Status writeback strobe |
| wb_word | output | 32 | Status word to be written back |
| len_mismatch | output | 1 | Count differs from the commanded length |
| rs_clr | output | 1 | Pulse requesting that run/stop be cleared |
| halted | output | 1 | Engine halted after an error |
| sg_int_err | output | 1 | Stale descriptor detected |

## Verification
A reference model in the bench is compared with the outputs on every clock while the block is driven with several kinds of transfer:
- **Clean transfers.** Multi-response transfers with matching counts and with short counts separate the count capture from the mismatch flag. A count wider than LEN_W shows whether masking is applied.
- **Error and reject cases.** Slave and decode errors arriving on non-final responses show whether the error bits are sticky. Zero-length and stale descriptors check the two screening paths, one of which writes back and one of which does not.
- **Halt and recovery.** Holding `eng_idle` low after an error separates the run/stop clear from the halted flag. Raising `rs_in` before and after `err_clr`, and presenting descriptors while halting or stopped, exercise the recovery order and the acceptance gate.
- **Micro build.** A second instance built with MICRO set receives the same stimulus, to show that its writeback stays silent.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  localparam int CNT_W  = 26;
  localparam int STAT_W = 32;

  typedef enum logic [1:0] {C_IDLE, C_BUSY, C_WB} core_st_e;
  typedef enum logic [1:0] {H_RUN, H_DRAIN, H_HALT, H_REARM} halt_st_e;
  typedef enum logic [1:0] {D_GOOD, D_STALE, D_ZERO} dsc_kind_e;

  typedef struct packed {
    logic dec;
    logic slv;
    logic intl;
  } err_t;

  // completed flag is the complement of any error; reserved pair forced to zero
  function automatic logic [STAT_W-1:0] pack_status(input err_t e, input logic [CNT_W-1:0] cnt);
    return {~(e.dec | e.slv | e.intl), e.dec, e.slv, e.intl, 2'b00, cnt};
  endfunction
endpackage

// File: rtl/dsw_dsc_check.sv
module dsw_dsc_check
  import dsw_pkg::*;
#(
  parameter int LEN_W = 26
) (
  input  logic [CNT_W-1:0] len_i,
  input  logic             cmplt_i,
  output logic [CNT_W-1:0] len_m_o,
  output dsc_kind_e        kind_o
);
  localparam logic [CNT_W-1:0] MASK = {CNT_W{1'b1}} >> (CNT_W - LEN_W);

  always_comb begin
    len_m_o = len_i & MASK;
    if (cmplt_i)              kind_o = D_STALE;
    else if (len_m_o == '0)   kind_o = D_ZERO;
    else                      kind_o = D_GOOD;
  end
endmodule

// File: rtl/dsw_resp_acc.sv
module dsw_resp_acc
  import dsw_pkg::*;
#(
  parameter int LEN_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             zero_i,
  input  logic             resp_v_i,
  input  logic             last_i,
  input  logic             slverr_i,
  input  logic             decerr_i,
  input  logic [CNT_W-1:0] bytes_i,
  output err_t             err_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] MASK = {CNT_W{1'b1}} >> (CNT_W - LEN_W);

  err_t             err_d, err_q;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             en;

  always_comb begin
    err_d = err_q;
    cnt_d = cnt_q;
    en    = start_i | resp_v_i;
    if (start_i) begin
      err_d      = '0;
      err_d.intl = zero_i;
      cnt_d      = '0;
    end else if (resp_v_i) begin
      err_d.slv = err_q.slv | slverr_i;
      err_d.dec = err_q.dec | decerr_i;
      if (last_i) cnt_d = bytes_i & MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      err_q <= err_d;
      cnt_q <= cnt_d;
    end
  end

  assign err_o = err_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/dsw_halt_seq.sv
module dsw_halt_seq
  import dsw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic err_evt_i,
  input  logic eng_idle_i,
  input  logic core_idle_i,
  input  logic err_clr_i,
  input  logic rs_i,
  output logic rs_clr_o,
  output logic halted_o,
  output logic run_o,
  output logic ack_o
);
  halt_st_e hs_d, hs_q;
  logic     halted_d, halted_q;
  logic     rs_clr_d, rs_clr_q;
  logic     rs_q;

  always_comb begin
    hs_d     = hs_q;
    halted_d = halted_q;
    rs_clr_d = 1'b0;
    case (hs_q)
      H_RUN:   if (err_evt_i) begin
                 rs_clr_d = 1'b1;
                 hs_d     = H_DRAIN;
               end
      H_DRAIN: if (eng_idle_i && core_idle_i) begin
                 halted_d = 1'b1;
                 hs_d     = H_HALT;
               end
      H_HALT:  if (err_clr_i) hs_d = H_REARM;
      H_REARM: if (rs_i && !rs_q) begin
                 halted_d = 1'b0;
                 hs_d     = H_RUN;
               end
      default: hs_d = H_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q     <= H_RUN;
      halted_q <= 1'b0;
      rs_clr_q <= 1'b0;
      rs_q     <= 1'b0;
    end else begin
      hs_q     <= hs_d;
      halted_q <= halted_d;
      rs_clr_q <= rs_clr_d;
      rs_q     <= rs_i;
    end
  end

  assign rs_clr_o = rs_clr_q;
  assign halted_o = halted_q;
  assign run_o    = (hs_q == H_RUN);
  assign ack_o    = (hs_q == H_HALT) && err_clr_i;
endmodule

// File: rtl/dsc_status_wb.sv
module dsc_status_wb
  import dsw_pkg::*;
#(
  parameter int LEN_W = 26,
  parameter bit MICRO = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dsc_valid,
  input  logic [CNT_W-1:0]  dsc_len,
  input  logic              dsc_cmplt,
  input  logic              rs_in,
  input  logic              err_clr,
  input  logic              eng_idle,
  output logic              mov_cmd_valid,
  output logic [CNT_W-1:0]  mov_cmd_len,
  input  logic              mov_resp,
  input  logic              mov_last,
  input  logic              mov_slverr,
  input  logic              mov_decerr,
  input  logic [CNT_W-1:0]  mov_bytes,
  output logic              wb_valid,
  output logic [STAT_W-1:0] wb_word,
  output logic              len_mismatch,
  output logic              rs_clr,
  output logic              halted,
  output logic              sg_int_err
);
  core_st_e         st_d, st_q;
  logic             cmd_d, cmd_q;
  logic [CNT_W-1:0] cmd_len_q;
  logic             sg_d, sg_q;
  logic [CNT_W-1:0] len_m;
  dsc_kind_e        kind;
  logic             accept, acc_start, err_evt, resp_v;
  logic             h_run, h_ack, core_idle;
  err_t             err;
  logic [CNT_W-1:0] cnt;

  dsw_dsc_check #(.LEN_W(LEN_W)) u_chk (
    .len_i(dsc_len), .cmplt_i(dsc_cmplt), .len_m_o(len_m), .kind_o(kind)
  );

  assign core_idle = (st_q == C_IDLE);
  assign accept    = core_idle && dsc_valid && rs_in && h_run;
  assign resp_v    = (st_q == C_BUSY) && mov_resp;

  always_comb begin
    st_d      = st_q;
    cmd_d     = 1'b0;
    sg_d      = sg_q;
    err_evt   = 1'b0;
    acc_start = 1'b0;
    if (h_ack) sg_d = 1'b0;
    case (st_q)
      C_IDLE: if (accept) begin
        case (kind)
          D_STALE: begin sg_d = 1'b1; err_evt = 1'b1; end
          D_ZERO:  begin acc_start = 1'b1; err_evt = 1'b1; st_d = C_WB; end
          default: begin acc_start = 1'b1; cmd_d = 1'b1; st_d = C_BUSY; end
        endcase
      end
      C_BUSY: if (mov_resp) begin
        err_evt = mov_slverr | mov_decerr;
        if (mov_last) st_d = C_WB;
      end
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= C_IDLE;
      cmd_q <= 1'b0;
      sg_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cmd_q <= cmd_d;
      sg_q  <= sg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cmd_len_q <= '0;
    else if (cmd_d) cmd_len_q <= len_m;
  end

  dsw_resp_acc #(.LEN_W(LEN_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .start_i(acc_start), .zero_i(kind == D_ZERO),
    .resp_v_i(resp_v), .last_i(mov_last), .slverr_i(mov_slverr),
    .decerr_i(mov_decerr), .bytes_i(mov_bytes), .err_o(err), .cnt_o(cnt)
  );

  dsw_halt_seq u_halt (
    .clk(clk), .rst_n(rst_n), .err_evt_i(err_evt), .eng_idle_i(eng_idle),
    .core_idle_i(core_idle), .err_clr_i(err_clr), .rs_i(rs_in),
    .rs_clr_o(rs_clr), .halted_o(halted), .run_o(h_run), .ack_o(h_ack)
  );

  generate
    if (MICRO) begin : g_micro
      assign wb_valid = 1'b0;
    end else begin : g_full
      assign wb_valid = (st_q == C_WB);
    end
  endgenerate

  assign wb_word       = pack_status(err, cnt);
  assign len_mismatch  = (st_q == C_WB) && (err == '0) && (cnt != cmd_len_q);
  assign mov_cmd_valid = cmd_q;
  assign mov_cmd_len   = cmd_len_q;
  assign sg_int_err    = sg_q;
endmodule

// File: rtl/dsw_sva_chk.sv
module dsw_sva_chk #(
  parameter int LEN_W = 26,
  parameter bit MICRO = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        dsc_valid,
  input logic [25:0] dsc_len,
  input logic        dsc_cmplt,
  input logic        eng_idle,
  input logic        mov_cmd_valid,
  input logic        wb_valid,
  input logic [31:0] wb_word,
  input logic        halted
);
  localparam logic [25:0] LMASK = {26{1'b1}} >> (26 - LEN_W);

  p_cnt_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ((wb_word[25:0] & ~LMASK) == 26'd0));

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_word[27:26] == 2'b00));

  p_no_cmd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mov_cmd_valid |-> ($past(dsc_valid) && (($past(dsc_len) & LMASK) != 26'd0)));

  p_cmplt_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_word[31] != (|wb_word[30:28])));

  p_no_cmd_stale_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mov_cmd_valid |-> !$past(dsc_cmplt));

  p_halt_on_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(eng_idle));

  p_wb_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);

  generate
    if (MICRO) begin : g_micro_chk
      p_micro_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_valid);
    end
  endgenerate
endmodule

bind dsc_status_wb dsw_sva_chk #(.LEN_W(LEN_W), .MICRO(MICRO)) u_sva (
  .clk(clk), .rst_n(rst_n), .dsc_valid(dsc_valid), .dsc_len(dsc_len),
  .dsc_cmplt(dsc_cmplt), .eng_idle(eng_idle), .mov_cmd_valid(mov_cmd_valid),
  .wb_valid(wb_valid), .wb_word(wb_word), .halted(halted)
);

// File: tb/dsc_status_wb_tb_top.sv
module dsc_status_wb_tb_top;
  localparam int CLK_P = 10;
  localparam int LW    = 16;
  localparam int MASKV = (1 << LW) - 1;

  logic        clk, rst_n;
  logic        dsc_valid, dsc_cmplt, rs_in, err_clr, eng_idle;
  logic [25:0] dsc_len, mov_bytes;
  logic        mov_resp, mov_last, mov_slverr, mov_decerr;
  logic        mov_cmd_valid, wb_valid, len_mismatch, rs_clr, halted, sg_int_err;
  logic [25:0] mov_cmd_len;
  logic [31:0] wb_word;
  logic        u_cmd, u_wb, u_mis, u_rsclr, u_halted, u_sg;
  logic [25:0] u_cmdlen;
  logic [31:0] u_word;

  dsc_status_wb #(.LEN_W(LW), .MICRO(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .dsc_valid(dsc_valid), .dsc_len(dsc_len),
    .dsc_cmplt(dsc_cmplt), .rs_in(rs_in), .err_clr(err_clr), .eng_idle(eng_idle),
    .mov_cmd_valid(mov_cmd_valid), .mov_cmd_len(mov_cmd_len), .mov_resp(mov_resp),
    .mov_last(mov_last), .mov_slverr(mov_slverr), .mov_decerr(mov_decerr),
    .mov_bytes(mov_bytes), .wb_valid(wb_valid), .wb_word(wb_word),
    .len_mismatch(len_mismatch), .rs_clr(rs_clr), .halted(halted), .sg_int_err(sg_int_err)
  );

  dsc_status_wb #(.LEN_W(26), .MICRO(1'b1)) dut_micro_i (
    .clk(clk), .rst_n(rst_n), .dsc_valid(dsc_valid), .dsc_len(dsc_len),
    .dsc_cmplt(dsc_cmplt), .rs_in(rs_in), .err_clr(err_clr), .eng_idle(eng_idle),
    .mov_cmd_valid(u_cmd), .mov_cmd_len(u_cmdlen), .mov_resp(mov_resp),
    .mov_last(mov_last), .mov_slverr(mov_slverr), .mov_decerr(mov_decerr),
    .mov_bytes(mov_bytes), .wb_valid(u_wb), .wb_word(u_word),
    .len_mismatch(u_mis), .rs_clr(u_rsclr), .halted(u_halted), .sg_int_err(u_sg)
  );

  int n_chk, n_err, n_wb, exp_wb;
  bit done;

  // behavioural reference model
  int m_st, m_h, m_cmdlen, m_bytes;
  bit m_cmd, m_rsclr, m_halted, m_sg, m_int, m_slv, m_dec, m_rsq;

  always @(posedge clk or negedge rst_n) begin
    int ost, oh, l;
    bit ev;
    if (!rst_n) begin
      m_st = 0; m_h = 0; m_cmdlen = 0; m_bytes = 0;
      m_cmd = 0; m_rsclr = 0; m_halted = 0; m_sg = 0;
      m_int = 0; m_slv = 0; m_dec = 0; m_rsq = 0;
    end else begin
      ost = m_st; oh = m_h; ev = 0;
      m_cmd = 0; m_rsclr = 0;
      if (ost == 0 && dsc_valid && rs_in && oh == 0) begin
        l = int'(dsc_len) & MASKV;
        if (dsc_cmplt) begin m_sg = 1; ev = 1; end
        else begin
          m_int = (l == 0); m_slv = 0; m_dec = 0; m_bytes = 0;
          if (l == 0) begin ev = 1; m_st = 2; end
          else begin m_cmd = 1; m_cmdlen = l; m_st = 1; end
        end
      end else if (ost == 1 && mov_resp) begin
        if (mov_slverr) m_slv = 1;
        if (mov_decerr) m_dec = 1;
        ev = mov_slverr | mov_decerr;
        if (mov_last) begin m_bytes = int'(mov_bytes) & MASKV; m_st = 2; end
      end else if (ost == 2) m_st = 0;
      if (oh == 0 && ev) begin m_rsclr = 1; m_h = 1; end
      else if (oh == 1 && eng_idle && ost == 0) begin m_halted = 1; m_h = 2; end
      else if (oh == 2 && err_clr) begin m_h = 3; m_sg = 0; end
      else if (oh == 3 && rs_in && !m_rsq) begin m_halted = 0; m_h = 0; end
      m_rsq = rs_in;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit mw, err;
    if (rst_n && !done) begin
      mw  = (m_st == 2);
      err = m_int | m_slv | m_dec;
      chk("R8", "wb_valid", {31'd0, wb_valid}, {31'd0, mw});
      if (mw)
        chk("R1 R2 R3 R4", "wb_word", wb_word,
            {~err, m_dec, m_slv, m_int, 2'b00, 26'(m_bytes)});
      chk("R3 R5 R11", "mov_cmd_valid", {31'd0, mov_cmd_valid}, {31'd0, m_cmd});
      if (m_cmd) chk("R1", "mov_cmd_len", {6'd0, mov_cmd_len}, 32'(m_cmdlen));
      chk("R6", "rs_clr", {31'd0, rs_clr}, {31'd0, m_rsclr});
      chk("R6 R7", "halted", {31'd0, halted}, {31'd0, m_halted});
      chk("R5", "sg_int_err", {31'd0, sg_int_err}, {31'd0, m_sg});
      chk("R10", "len_mismatch", {31'd0, len_mismatch},
          {31'd0, mw && !err && (m_bytes != m_cmdlen)});
      chk("R9", "micro wb_valid", {31'd0, u_wb}, 32'd0);
      chk("R9", "micro halted", {31'd0, u_halted}, {31'd0, m_halted});
      if (wb_valid) n_wb++;
    end
  end

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic put_dsc(input int len, input bit cm);
    dsc_valid = 1; dsc_len = 26'(len); dsc_cmplt = cm;
    step();
    dsc_valid = 0; dsc_cmplt = 0;
  endtask

  task automatic resp(input int bytes, input bit slv, input bit dec, input bit last);
    mov_resp = 1; mov_bytes = 26'(bytes); mov_slverr = slv; mov_decerr = dec; mov_last = last;
    step();
    mov_resp = 0; mov_slverr = 0; mov_decerr = 0; mov_last = 0;
  endtask

  task automatic recover();
    rs_in = 0; step();
    err_clr = 1; step();
    err_clr = 0; rs_in = 1; step(2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    n_chk = 0; n_err = 0; n_wb = 0; exp_wb = 0; done = 0;
    rst_n = 0; dsc_valid = 0; dsc_len = 0; dsc_cmplt = 0; rs_in = 0;
    err_clr = 0; eng_idle = 1; mov_resp = 0; mov_last = 0;
    mov_slverr = 0; mov_decerr = 0; mov_bytes = 0;
    step(2);
    chk("R6", "reset halted", {31'd0, halted}, 32'd0);
    chk("R8", "reset wb_valid", {31'd0, wb_valid}, 32'd0);
    chk("R3", "reset mov_cmd_valid", {31'd0, mov_cmd_valid}, 32'd0);
    chk("R5", "reset sg_int_err", {31'd0, sg_int_err}, 32'd0);
    rst_n = 1; rs_in = 1; step(2);

    // R8 R1: clean two-response transfer
    put_dsc(100, 0); exp_wb++; step();
    resp(60, 0, 0, 0); resp(100, 0, 0, 1); step(2);
    // R10: short count
    put_dsc(50, 0); exp_wb++; step();
    resp(40, 0, 0, 1); step(2);
    // R1: count wider than LEN_W is masked
    put_dsc(65535, 0); exp_wb++; step();
    resp(26'h3FFFFFF, 0, 0, 1); step(2);

    // R4 R6 R7: sticky slave error, delayed drain
    eng_idle = 0;
    put_dsc(200, 0); exp_wb++; step();
    resp(80, 1, 0, 0);
    rs_in = 0;
    resp(200, 0, 0, 1); step(3);
    rs_in = 1;
    put_dsc(30, 0); step(2);             // R11: ignored during drain
    rs_in = 0; eng_idle = 1; step(3);
    rs_in = 1; step(2);                  // R7: rise before err_clr
    chk("R7", "halted after early rise", {31'd0, halted}, 32'd1);
    recover();
    chk("R7", "halted after recovery", {31'd0, halted}, 32'd0);

    // R4: decode error
    put_dsc(300, 0); exp_wb++; step();
    resp(300, 0, 1, 1); step(4);
    recover();
    // R3: zero length
    put_dsc(0, 0); exp_wb++; step(4);
    recover();
    // R5: stale descriptor
    put_dsc(64, 1); step(4);
    chk("R5", "sg_int_err held", {31'd0, sg_int_err}, 32'd1);
    recover();
    chk("R5", "sg_int_err cleared", {31'd0, sg_int_err}, 32'd0);
    // R11: run/stop low
    rs_in = 0;
    put_dsc(10, 0); step(3);
    rs_in = 1; step(2);

    chk("R8", "writeback count", 32'(n_wb), 32'(exp_wb));
    finish_run();
  end
endmodule